// File: doc/BRIEF.md
# Watermark FIFO with Interrupt Status

This block is the data queue that sits between a processor's register port and a serial shift engine. One instance serves the receive direction, where the engine pushes and register reads of the data location pop. Another instance serves the transmit direction, where register writes of the data location push and the engine pops. The parameter `IS_RX` picks the direction. Words are stored 32 bits wide. A width mode trims each pushed word to 8, 16 or 32 significant bits.

Software controls the queue through a small register port. A start bit gates all traffic. A self-clearing reset bit empties the queue. A status word gives the fill level, full and empty, plus three comparisons of the level against programmable level-check values. An 8-bit watermark is also programmable. The block keeps a sticky interrupt status vector. It is fed by queue events (overflow, underflow, reaching full, draining to empty, crossing the watermark) and by two engine event inputs (transfer done, frame end). Status bits are cleared by writing ones. A single registered interrupt line reports any status bit whose enable is set.

Top module: `wm_fifo_irq`

## Requirements
- R1: After reset the queue is empty: the status word (address 3) reads level 0, full bit 8 clear and empty bit 9 set, the interrupt status reads 0 and `irq` is low.
- R2: Words leave in the order they entered. Status bits 7:0 give the number of stored words, up to DEPTH (64). Bit 8 is set exactly at DEPTH and bit 9 exactly at 0.
- R3: While the start bit (bit 1 of the operation register, address 2) is 0, pushes and pops are ignored and the level is unchanged.
- R4: Writing 1 to bit 0 of the operation register empties the queue in one cycle, whatever the start bit is.
- R5: The width field (control register address 0, bits 1:0) trims pushed data: 0 keeps bits 7:0, 1 keeps bits 15:0, 2 and 3 keep all 32 bits. Upper bits read as zero.
- R6: A push into a full queue is dropped, leaves the stored words intact and sets interrupt status bit 2.
- R7: A pop from an empty queue sets interrupt status bit 3 and changes no stored word.
- R8: The receive instance sets bit 8 when the level rises from below the watermark (control bits 9:2) to at least the watermark. The transmit instance sets bit 9 when the level falls from above the watermark to at most the watermark.
- R9: Bit 6 sets when the level reaches DEPTH. Bit 7 sets when the level goes from nonzero to zero.
- R10: A pulse on `ev_done` sets bit 0 (receive) or bit 1 (transmit). A pulse on `ev_frame_end` sets bit 10.
- R11: Writing the interrupt status register (address 5) clears each bit written as 1 and keeps the others. Writing 0x1FFF clears all of them. A new event in the same cycle wins over the clear.
- R12: `irq` is the registered OR of status AND enable (address 4, same bit positions). It stays high until the enabled bits are cleared and ignores disabled bits.
- R13: The level-check register (address 1) holds three 6-bit values at bits 5:0, 15:10 and 25:20. Status bits 10, 11 and 12 report level >= each of them. Control, level-check and operation registers read back what was written. Address 6 is the data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 6 pops in receive mode) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_xfer | input | 1 | Engine strobe: push (receive) or pop (transmit) |
| eng_wdata | input | DW | Engine data pushed in receive mode |
| eng_rdata | output | DW | Word popped by the last pop |
| ev_done | input | 1 | Engine transfer-done pulse |
| ev_frame_end | input | 1 | Engine frame-end pulse |
| irq | output | 1 | Interrupt request |

## Verification
The receive queue is swept through every level from empty to full with a distinct word at each step, and the status word is compared after each push. This separates level counting, the full and empty edges and the three level-check comparisons, which change at different levels. It is then drained completely, which shows ordering, and pushed and popped past its limits, which separates dropped traffic from corrupted storage. Single pushes under each width mode with one pattern that has every byte distinct show which bits are kept. A transmit instance drained one word at a time across its watermark shows that the crossing fires only on the step that reaches it. Enable masks that cover some pending bits and not others show the difference between pending status and the interrupt line.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;
  // register addresses
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LCHK = 3'd1;
  localparam logic [2:0] A_OP   = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_IST  = 3'd5;
  localparam logic [2:0] A_DATA = 3'd6;

  // field offsets
  localparam int CTRL_THR_LSB = 2;
  localparam int CHK0_LSB     = 0;
  localparam int CHK1_LSB     = 10;
  localparam int CHK2_LSB     = 20;

  // interrupt status bit positions
  localparam int IRQ_W   = 13;
  localparam int B_RXDONE = 0;
  localparam int B_TXDONE = 1;
  localparam int B_OVF    = 2;
  localparam int B_UDF    = 3;
  localparam int B_FULL   = 6;
  localparam int B_EMPTY  = 7;
  localparam int B_RXTHR  = 8;
  localparam int B_TXTHR  = 9;
  localparam int B_FEND   = 10;

  typedef enum logic [1:0] {
    WM_BYTE = 2'd0,
    WM_HALF = 2'd1,
    WM_WORD = 2'd2,
    WM_WIDE = 2'd3
  } width_mode_e;
endpackage

// File: rtl/wm_fifo_store.sv
module wm_fifo_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             udf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [PW-1:0]    PTR_END = PW'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [LVL_W-1:0] level_q;
  logic [DW-1:0]    pop_q;
  logic             do_push, do_pop;

  assign full    = (level_q == LVL_MAX);
  assign empty   = (level_q == '0);
  assign do_push = en && push && !full;
  assign do_pop  = en && pop && !empty;
  assign ovf     = en && push && full;
  assign udf     = en && pop && empty;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_END) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_END) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      level_q <= level_q + 1'b1;
      else if (do_pop && !do_push) level_q <= level_q - 1'b1;
    end
  end

  // block-RAM style: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) pop_q <= mem[rp_q];
  end

  assign pop_data = pop_q;
  assign level    = level_q;

  // R2
  level_le_depth_chk: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_MAX);
  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !pop && !clr) |=> (level_q == $past(level_q)));
  // R4
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level_q == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(level_q));
endmodule

// File: rtl/wm_irq_bank.sv
module wm_irq_bank
  import wm_fifo_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int THR_W = 8,
  parameter int DEPTH = 64,
  parameter bit IS_RX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  input  logic             ovf,
  input  logic             udf,
  input  logic             ev_done,
  input  logic             ev_fend,
  input  logic             en_we,
  input  logic             st_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] st,
  output logic [IRQ_W-1:0] en,
  output logic             irq
);
  logic [LVL_W-1:0] prev_q;
  logic [IRQ_W-1:0] st_q, en_q, set_v, clr_v;
  logic             irq_q;
  int               lv, pv, tv;

  always_comb begin
    lv    = int'(level);
    pv    = int'(prev_q);
    tv    = int'(thr);
    set_v = '0;
    set_v[B_OVF]   = ovf;
    set_v[B_UDF]   = udf;
    set_v[B_FULL]  = (pv != DEPTH) && (lv == DEPTH);
    set_v[B_EMPTY] = (pv != 0) && (lv == 0);
    set_v[B_FEND]  = ev_fend;
    if (IS_RX) begin
      set_v[B_RXDONE] = ev_done;
      set_v[B_RXTHR]  = (pv < tv) && (lv >= tv);
    end else begin
      set_v[B_TXDONE] = ev_done;
      set_v[B_TXTHR]  = (pv > tv) && (lv <= tv);
    end
    clr_v = st_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      st_q   <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= level;
      st_q   <= (st_q & ~clr_v) | set_v;
      if (en_we) en_q <= wdata;
      irq_q  <= |(st_q & en_q);
    end
  end

  assign st  = st_q;
  assign en  = en_q;
  assign irq = irq_q;

  // R10
  fend_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_fend |=> st_q[B_FEND]);
  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st_we && |(wdata & ~set_v)) |=> ((st_q & $past(wdata & ~set_v)) == '0));
endmodule

// File: rtl/wm_fifo_irq.sv
module wm_fifo_irq
  import wm_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int THR_W = 8,
  parameter int CHK_W = 6,
  parameter bit IS_RX = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          eng_xfer,
  input  logic [DW-1:0] eng_wdata,
  output logic [DW-1:0] eng_rdata,
  input  logic          ev_done,
  input  logic          ev_frame_end,
  output logic          irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [1:0]       width_q;
  logic [THR_W-1:0] thr_q;
  logic [CHK_W-1:0] chk0_q, chk1_q, chk2_q;
  logic             start_q;
  logic [31:0]      rd_q;
  logic             data_sel_q;

  logic             clr, push, pop, full, empty, ovf, udf;
  logic [DW-1:0]    raw, masked, pop_data;
  logic [LVL_W-1:0] level;
  logic [IRQ_W-1:0] st, en;
  logic [31:0]      stat_w;
  logic             wr_data_hit, rd_data_hit;

  assign wr_data_hit = reg_wr && (reg_addr == A_DATA);
  assign rd_data_hit = reg_rd && (reg_addr == A_DATA);
  assign clr         = reg_wr && (reg_addr == A_OP) && reg_wdata[0];

  // direction selects which side pushes and which pops
  assign push = IS_RX ? eng_xfer : wr_data_hit;
  assign pop  = IS_RX ? rd_data_hit : eng_xfer;
  assign raw  = IS_RX ? eng_wdata : reg_wdata[DW-1:0];

  always_comb begin
    case (width_mode_e'(width_q))
      WM_BYTE: masked = {{(DW-8){1'b0}}, raw[7:0]};
      WM_HALF: masked = {{(DW-16){1'b0}}, raw[15:0]};
      default: masked = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      thr_q   <= '0;
      chk0_q  <= '0;
      chk1_q  <= '0;
      chk2_q  <= '0;
      start_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          width_q <= reg_wdata[1:0];
          thr_q   <= reg_wdata[CTRL_THR_LSB +: THR_W];
        end
        A_LCHK: begin
          chk0_q <= reg_wdata[CHK0_LSB +: CHK_W];
          chk1_q <= reg_wdata[CHK1_LSB +: CHK_W];
          chk2_q <= reg_wdata[CHK2_LSB +: CHK_W];
        end
        A_OP:    start_q <= reg_wdata[1];
        default: ;
      endcase
    end
  end

  wm_fifo_store #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .en       (start_q),
    .push     (push),
    .push_data(masked),
    .pop      (pop),
    .pop_data (pop_data),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .ovf      (ovf),
    .udf      (udf)
  );

  wm_irq_bank #(.LVL_W(LVL_W), .THR_W(THR_W), .DEPTH(DEPTH), .IS_RX(IS_RX)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .level  (level),
    .thr    (thr_q),
    .ovf    (ovf),
    .udf    (udf),
    .ev_done(ev_done),
    .ev_fend(ev_frame_end),
    .en_we  (reg_wr && (reg_addr == A_IEN)),
    .st_we  (reg_wr && (reg_addr == A_IST)),
    .wdata  (reg_wdata[IRQ_W-1:0]),
    .st     (st),
    .en     (en),
    .irq    (irq)
  );

  always_comb begin
    stat_w       = '0;
    stat_w[7:0]  = 8'(level);
    stat_w[8]    = full;
    stat_w[9]    = empty;
    stat_w[10]   = int'(level) >= int'(chk0_q);
    stat_w[11]   = int'(level) >= int'(chk1_q);
    stat_w[12]   = int'(level) >= int'(chk2_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      data_sel_q <= 1'b0;
    end else if (reg_rd) begin
      data_sel_q <= (reg_addr == A_DATA);
      rd_q       <= '0;
      case (reg_addr)
        A_CTRL: begin
          rd_q[1:0]                     <= width_q;
          rd_q[CTRL_THR_LSB +: THR_W]   <= thr_q;
        end
        A_LCHK: begin
          rd_q[CHK0_LSB +: CHK_W] <= chk0_q;
          rd_q[CHK1_LSB +: CHK_W] <= chk1_q;
          rd_q[CHK2_LSB +: CHK_W] <= chk2_q;
        end
        A_OP:    rd_q[1]         <= start_q;
        A_STAT:  rd_q            <= stat_w;
        A_IEN:   rd_q[IRQ_W-1:0] <= en;
        A_IST:   rd_q[IRQ_W-1:0] <= st;
        default: ;
      endcase
    end
  end

  assign reg_rdata = data_sel_q ? 32'(pop_data) : rd_q;
  assign eng_rdata = pop_data;
endmodule

// File: tb/sim_wm_fifo_irq.sv
`timescale 1ns/100ps
module sim_wm_fifo_irq;
  localparam logic [2:0] CTRL = 0, LCHK = 1, OP = 2, STAT = 3, IEN = 4, IST = 5, DATA = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wr0 = 0, rd0 = 0, x0 = 0, dn0 = 0, fe0 = 0;
  logic [2:0]  a0 = 0;
  logic [31:0] wd0 = 0, ew0 = 0, rdat0, er0;
  logic        irq0;
  logic        wr1 = 0, rd1 = 0, x1 = 0, dn1 = 0, fe1 = 0;
  logic [2:0]  a1 = 0;
  logic [31:0] wd1 = 0, ew1 = 0, rdat1, er1;
  logic        irq1;

  wm_fifo_irq #(.IS_RX(1'b1)) u0 (
    .clk(clk), .rst(rst), .reg_wr(wr0), .reg_rd(rd0), .reg_addr(a0),
    .reg_wdata(wd0), .reg_rdata(rdat0), .eng_xfer(x0), .eng_wdata(ew0),
    .eng_rdata(er0), .ev_done(dn0), .ev_frame_end(fe0), .irq(irq0));

  wm_fifo_irq #(.IS_RX(1'b0)) u1 (
    .clk(clk), .rst(rst), .reg_wr(wr1), .reg_rd(rd1), .reg_addr(a1),
    .reg_wdata(wd1), .reg_rdata(rdat1), .eng_xfer(x1), .eng_wdata(ew1),
    .eng_rdata(er1), .ev_done(dn1), .ev_frame_end(fe1), .irq(irq1));

  int checks = 0, failures = 0;
  bit finished = 0;
  int sc = 0, lc = 0, hc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input int u, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (u == 0) begin wr0 = 1; a0 = a; wd0 = d; end
    else        begin wr1 = 1; a1 = a; wd1 = d; end
    @(negedge clk);
    wr0 = 0; wr1 = 0;
  endtask

  task automatic rreg(input int u, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    if (u == 0) begin rd0 = 1; a0 = a; end
    else        begin rd1 = 1; a1 = a; end
    @(negedge clk);
    rd0 = 0; rd1 = 0;
    d = (u == 0) ? rdat0 : rdat1;
  endtask

  task automatic xfer(input int u, input logic [31:0] d);
    @(negedge clk);
    if (u == 0) begin x0 = 1; ew0 = d; end else begin x1 = 1; ew1 = d; end
    @(negedge clk);
    x0 = 0; x1 = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] stat_exp(input int lv);
    logic [31:0] s;
    s = 32'(lv);
    s[8]  = (lv == 64);
    s[9]  = (lv == 0);
    s[10] = (lv >= sc);
    s[11] = (lv >= lc);
    s[12] = (lv >= hc);
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    rreg(0, STAT, r); check("R1 stat", r, stat_exp(0));
    rreg(0, IST, r);  check("R1 irq status", r, 0);
    check("R1 irq", {31'd0, irq0}, 0);

    // R13 register readback
    sc = 3; lc = 10; hc = 40;
    wreg(0, LCHK, 32'(sc) | (32'(lc) << 10) | (32'(hc) << 20));
    rreg(0, LCHK, r); check("R13 lchk", r, 32'(sc) | (32'(lc) << 10) | (32'(hc) << 20));
    wreg(0, CTRL, 32'd2 | (32'd32 << 2));
    rreg(0, CTRL, r); check("R13 ctrl", r, 32'd2 | (32'd32 << 2));

    // R3 pushes ignored while stopped
    xfer(0, 32'h1111_1111); xfer(0, 32'h2222_2222);
    rreg(0, STAT, r); check("R3 stopped push", r, stat_exp(0));

    wreg(0, OP, 32'h2);
    rreg(0, OP, r); check("R13 op", r, 32'h2);

    // R2 R13 fill sweep
    for (int i = 0; i < 64; i++) begin
      xfer(0, 32'hC0DE_0000 + 32'(i) * 32'h0001_0103);
      rreg(0, STAT, r); check($sformatf("R2 R13 level %0d", i + 1), r, stat_exp(i + 1));
    end
    // R6 overflow
    xfer(0, 32'hDEAD_BEEF);
    rreg(0, STAT, r); check("R6 level after overflow", r, stat_exp(64));
    idle(2);
    // R6 R8 R9 overflow, rise past watermark 32, full reached
    rreg(0, IST, r); check("R6 R8 R9 status", r, (1 << 2) | (1 << 6) | (1 << 8));
    check("R12 masked irq", {31'd0, irq0}, 0);

    // R2 drain in order
    for (int i = 0; i < 64; i++) begin
      rreg(0, DATA, r); check($sformatf("R2 data %0d", i), r, 32'hC0DE_0000 + 32'(i) * 32'h0001_0103);
    end
    rreg(0, STAT, r); check("R2 empty", r, stat_exp(0));
    // R7 underflow
    rreg(0, DATA, r); check("R7 data unchanged", r, 32'hC0DE_0000 + 32'd63 * 32'h0001_0103);
    idle(2);
    rreg(0, IST, r); check("R7 R9 status", r, (1 << 2) | (1 << 3) | (1 << 6) | (1 << 7) | (1 << 8));

    // R11 write-one-to-clear
    wreg(0, IST, 1 << 2);
    rreg(0, IST, r); check("R11 partial clear", r, (1 << 3) | (1 << 6) | (1 << 7) | (1 << 8));
    wreg(0, IST, 32'h1FFF);
    rreg(0, IST, r); check("R11 clear all", r, 0);

    // R10 R12 events and irq
    wreg(0, IEN, 1 << 10);
    @(negedge clk) dn0 = 1; @(negedge clk) dn0 = 0;
    idle(3);
    check("R12 disabled bit no irq", {31'd0, irq0}, 0);
    @(negedge clk) fe0 = 1; @(negedge clk) fe0 = 0;
    idle(3);
    check("R12 irq high", {31'd0, irq0}, 1);
    rreg(0, IST, r); check("R10 done and frame end", r, (1 << 0) | (1 << 10));
    idle(5);
    check("R12 irq held", {31'd0, irq0}, 1);
    wreg(0, IST, 1 << 10);
    idle(3);
    check("R12 irq cleared", {31'd0, irq0}, 0);

    // R5 width modes
    wreg(0, CTRL, 32'd0 | (32'd32 << 2));
    xfer(0, 32'hA5C3_5A7E); rreg(0, DATA, r); check("R5 byte", r, 32'h0000_007E);
    wreg(0, CTRL, 32'd1 | (32'd32 << 2));
    xfer(0, 32'hA5C3_5A7E); rreg(0, DATA, r); check("R5 half", r, 32'h0000_5A7E);
    wreg(0, CTRL, 32'd3 | (32'd32 << 2));
    xfer(0, 32'hA5C3_5A7E); rreg(0, DATA, r); check("R5 full width", r, 32'hA5C3_5A7E);

    // R3 pop ignored when stopped, R4 pointer reset
    xfer(0, 1); xfer(0, 2); xfer(0, 3);
    wreg(0, OP, 32'h0);
    rreg(0, DATA, r);
    rreg(0, STAT, r); check("R3 stopped pop", r, stat_exp(3));
    wreg(0, OP, 32'h3);
    rreg(0, STAT, r); check("R4 reset op", r, stat_exp(0));

    // R8 transmit instance: downward crossing of watermark 2
    wreg(1, CTRL, 32'd2 | (32'd2 << 2));
    wreg(1, OP, 32'h2);
    for (int i = 0; i < 5; i++) wreg(1, DATA, 32'h5000_0000 + 32'(i));
    wreg(1, IST, 32'h1FFF);
    xfer(1, 0); check("R2 tx order 0", er1, 32'h5000_0000);
    xfer(1, 0); check("R2 tx order 1", er1, 32'h5000_0001);
    idle(2);
    rreg(1, IST, r); check("R8 tx no crossing at 3", r, 0);
    xfer(1, 0);
    idle(2);
    rreg(1, IST, r); check("R8 tx crossing at 2", r, 1 << 9);
    @(negedge clk) dn1 = 1; @(negedge clk) dn1 = 0;
    idle(2);
    rreg(1, IST, r); check("R10 tx done", r, (1 << 9) | (1 << 1));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule